// File: doc/BRIEF.md
# Receiver Sleep/Run Duty-Cycle Controller

This block decides, cycle by cycle, whether a low-power radio receiver is powered for reception (run) or parked (sleep). Three operating modes are selected by a two-bit input. The unconfigured mode keeps the receiver permanently awake with no timer running. The external mode hands the decision to a strobe pin. The internal mode alternates a programmable run window with a programmable sleep interval. A high strobe level forces run in every mode, within the same cycle.

In internal mode the receiver remains awake past the end of a run window only if the downstream frame decoder flags a valid identifier while the window is open. That extended run ends when the decoder reports end-of-message, or when a fixed hold timeout runs out, and cycling then resumes with a sleep interval. Each time the receiver wakes, a settling flag stays low for a fixed number of slow ticks. Identifier reports that arrive before the flag rises are discarded. All durations are counted in slow ticks, and one slow tick is `TICK_DIV` system clocks. The configuration inputs are driven from outside the block, so sleeping never disturbs them.

Top module: `rx_duty_ctrl`

## Requirements
- R1: A synchronous reset puts the block into the always-awake state: `run_en_o` is 1 and `settled_o` is 0. `settled_o` then rises `SETTLE_TICKS*TICK_DIV` cycles later.
- R2: `cycle_mode_i` encoding: 2'b00 keeps `run_en_o` at 1 with no cycling. 2'b01 selects external strobing. 2'b10 and 2'b11 both select internal cycling.
- R3: In external mode, `run_en_o` equals `strobe_i`. A change on `strobe_i` shows on `run_en_o` in the same cycle, with no clock edge in between.
- R4: In any mode, `strobe_i` high drives `run_en_o` high in the same cycle. A high strobe sampled during an internal sleep interval also opens a fresh run window.
- R5: When internal mode is selected, cycling begins with a run window of about `run_len_i*TICK_DIV` cycles. A sleep interval of about `sleep_len_i*TICK_DIV` cycles follows, and the two then alternate.
- R6: `settled_o` is 0 whenever `run_en_o` is 0. After each wake, `settled_o` rises `SETTLE_TICKS*TICK_DIV` cycles after the last clock edge that saw `run_en_o` low.
- R7: `id_valid_i` has no effect while `settled_o` is 0. A run window in which the only identifier reports come before settling ends on its timer.
- R8: `id_valid_i` high while `settled_o` is 1 during a run window keeps the receiver in run past the end of that window.
- R9: `eom_i` high during an identifier-held run ends it at the next edge, and a sleep interval follows.
- R10: An identifier-held run with no end-of-message ends after `HOLD_TICKS*TICK_DIV` cycles, and a sleep interval follows.
- R11: The length inputs are sampled again at every phase start. With the lengths unchanged, the run/sleep pattern repeats with a constant period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cycle_mode_i | input | 2 | 00 always awake, 01 external strobe, 1x internal cycling |
| strobe_i | input | 1 | External wake strobe, active high |
| sleep_len_i | input | CNT_W | Sleep interval in slow ticks |
| run_len_i | input | CNT_W | Run window in slow ticks |
| id_valid_i | input | 1 | Frame decoder reports a matching identifier |
| eom_i | input | 1 | Frame decoder reports end of message |
| run_en_o | output | 1 | Receiver run enable |
| settled_o | output | 1 | Wake-up settling period has elapsed |

## Verification
The bench drops a strobe into the middle of a sleep interval. It then samples at a point that is still asleep if the strobe only masked the timer, and awake if the strobe restarted the window. It sends an identifier inside a run window but before settling. A design that lets that report through would hold the receiver awake where it should sleep. Identifier-held runs are ended once by end-of-message and once by the hold timeout, so a design missing either exit stays awake too long. In external mode, the strobe is changed between clock edges to expose any registered path that adds a cycle of latency.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
   localparam logic [1:0] MODE_ON  = 2'b00;
   localparam logic [1:0] MODE_EXT = 2'b01;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_EXT   = 3'd1,
      ST_SLEEP = 3'd2,
      ST_WIN   = 3'd3,
      ST_HOLD  = 3'd4
   } rdc_state_t;
endpackage

// File: rtl/rdc_tick_timer.sv
module rdc_tick_timer #(
   parameter int              TICK_DIV = 4,
   parameter int              CNT_W    = 8,
   parameter logic [CNT_W-1:0] RST_LEN = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] len,
   output logic             expired
);
   localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   logic [CNT_W-1:0] cnt_q;
   logic             tick;

   generate
      if (TICK_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (rst || load) begin
               pre_q <= '0;
            end else if (!expired) begin
               pre_q <= (pre_q == PW'(TICK_DIV - 1)) ? '0 : pre_q + 1'b1;
            end
         end
         assign tick = (pre_q == PW'(TICK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= RST_LEN;
         expired <= (RST_LEN == '0);
      end else if (load) begin
         cnt_q   <= len;
         expired <= (len == '0);
      end else if (!expired && tick) begin
         if (cnt_q <= CNT_W'(1)) begin
            cnt_q   <= '0;
            expired <= 1'b1;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/rdc_seq.sv
module rdc_seq
   import rdc_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int HOLD_TICKS = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       mode,
   input  logic             strobe,
   input  logic             id_ok,
   input  logic             eom,
   input  logic             tmr_done,
   input  logic [CNT_W-1:0] sleep_len,
   input  logic [CNT_W-1:0] run_len,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_len,
   output logic             core_run
);
   localparam logic [CNT_W-1:0] HOLD_LEN = CNT_W'(HOLD_TICKS);

   rdc_state_t st_q, st_d;

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_len  = run_len;
      if (mode == MODE_ON) begin
         st_d = ST_IDLE;
      end else if (mode == MODE_EXT) begin
         st_d = ST_EXT;
      end else begin
         case (st_q)
            ST_IDLE, ST_EXT: begin
               st_d     = ST_WIN;
               tmr_load = 1'b1;
            end
            ST_SLEEP: begin
               if (strobe || tmr_done) begin
                  st_d     = ST_WIN;
                  tmr_load = 1'b1;
               end
            end
            ST_WIN: begin
               if (id_ok) begin
                  st_d     = ST_HOLD;
                  tmr_load = 1'b1;
                  tmr_len  = HOLD_LEN;
               end else if (tmr_done) begin
                  st_d     = ST_SLEEP;
                  tmr_load = 1'b1;
                  tmr_len  = sleep_len;
               end
            end
            ST_HOLD: begin
               if (eom || tmr_done) begin
                  st_d     = ST_SLEEP;
                  tmr_load = 1'b1;
                  tmr_len  = sleep_len;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_IDLE;
      else     st_q <= st_d;
   end

   assign core_run = (st_q == ST_IDLE) || (st_q == ST_WIN) || (st_q == ST_HOLD);
endmodule

// File: rtl/rx_duty_ctrl.sv
module rx_duty_ctrl #(
   parameter int TICK_DIV           = 1000,
   parameter int CNT_W              = 12,
   parameter int SETTLE_TICKS       = 100,
   parameter int HOLD_TICKS         = 2000,
   parameter int STROBE_SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       cycle_mode_i,
   input  logic             strobe_i,
   input  logic [CNT_W-1:0] sleep_len_i,
   input  logic [CNT_W-1:0] run_len_i,
   input  logic             id_valid_i,
   input  logic             eom_i,
   output logic             run_en_o,
   output logic             settled_o
);
   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (SETTLE_TICKS < 1 || SETTLE_TICKS >= (1 << CNT_W)) begin : g_bad_settle
         $error("SETTLE_TICKS must be in 1 .. 2**CNT_W-1");
      end
      if (HOLD_TICKS < 1 || HOLD_TICKS >= (1 << CNT_W)) begin : g_bad_hold
         $error("HOLD_TICKS must be in 1 .. 2**CNT_W-1");
      end
      if (STROBE_SYNC_STAGES < 0 || STROBE_SYNC_STAGES > 4) begin : g_bad_sync
         $error("STROBE_SYNC_STAGES must be in 0 .. 4");
      end
   endgenerate

   localparam logic [CNT_W-1:0] SETTLE_LEN = CNT_W'(SETTLE_TICKS);

   logic             strobe_s;
   logic             core_run;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_len;
   logic             tmr_done;
   logic             settle_done;

   generate
      if (STROBE_SYNC_STAGES == 0) begin : g_strobe_direct
         assign strobe_s = strobe_i;
      end else begin : g_strobe_sync
         logic [STROBE_SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (rst) sync_q <= '0;
            else     sync_q <= {sync_q[STROBE_SYNC_STAGES-1:0], strobe_i} >> 0;
         end
         assign strobe_s = sync_q[STROBE_SYNC_STAGES-1];
      end
   endgenerate

   rdc_seq #(
      .CNT_W      (CNT_W),
      .HOLD_TICKS (HOLD_TICKS)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .mode      (cycle_mode_i),
      .strobe    (strobe_s),
      .id_ok     (id_valid_i && settled_o),
      .eom       (eom_i),
      .tmr_done  (tmr_done),
      .sleep_len (sleep_len_i),
      .run_len   (run_len_i),
      .tmr_load  (tmr_load),
      .tmr_len   (tmr_len),
      .core_run  (core_run)
   );

   rdc_tick_timer #(
      .TICK_DIV (TICK_DIV),
      .CNT_W    (CNT_W),
      .RST_LEN  ('0)
   ) u_phase_tmr (
      .clk     (clk),
      .rst     (rst),
      .load    (tmr_load),
      .len     (tmr_len),
      .expired (tmr_done)
   );

   rdc_tick_timer #(
      .TICK_DIV (TICK_DIV),
      .CNT_W    (CNT_W),
      .RST_LEN  (SETTLE_LEN)
   ) u_settle_tmr (
      .clk     (clk),
      .rst     (rst),
      .load    (!run_en_o),
      .len     (SETTLE_LEN),
      .expired (settle_done)
   );

   assign run_en_o  = core_run || strobe_i;
   assign settled_o = settle_done && run_en_o;
endmodule

// File: rtl/rdc_checker.sv
module rdc_checker #(
   parameter int STROBE_SYNC_STAGES = 0
) (
   input logic       clk,
   input logic       rst,
   input logic [1:0] cycle_mode_i,
   input logic       strobe_i,
   input logic       run_en_o,
   input logic       settled_o
);
   AST_STROBE_FORCES_RUN: assert property (@(posedge clk) disable iff (rst)
      strobe_i |-> run_en_o); // R4

   AST_ASLEEP_UNSETTLED: assert property (@(posedge clk) disable iff (rst)
      !run_en_o |=> (!run_en_o || !settled_o)); // R6

   AST_WAKE_UNSETTLED: assert property (@(posedge clk) disable iff (rst)
      $rose(run_en_o) |-> !settled_o); // R6

   AST_ON_MODE_AWAKE: assert property (@(posedge clk) disable iff (rst)
      (cycle_mode_i == 2'b00) |=> run_en_o); // R2

   AST_EXT_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (rst)
      ((cycle_mode_i == 2'b01) && $past(cycle_mode_i == 2'b01) && !$past(rst))
         |-> (run_en_o == strobe_i)); // R3
endmodule

bind rx_duty_ctrl rdc_checker #(
   .STROBE_SYNC_STAGES (STROBE_SYNC_STAGES)
) u_rdc_chk (
   .clk          (clk),
   .rst          (rst),
   .cycle_mode_i (cycle_mode_i),
   .strobe_i     (strobe_i),
   .run_en_o     (run_en_o),
   .settled_o    (settled_o)
);

// File: tb/sim_rx_duty_ctrl.sv
`timescale 1ns/1ps
module sim_rx_duty_ctrl;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    mode = 2'b00;
   logic          strobe = 1'b0;
   logic [CW-1:0] sleep_len = 8'd6;
   logic [CW-1:0] run_len = 8'd8;
   logic          id_valid = 1'b0;
   logic          eom = 1'b0;
   logic          run_en;
   logic          settled;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   rx_duty_ctrl #(
      .TICK_DIV           (4),
      .CNT_W              (CW),
      .SETTLE_TICKS       (5),
      .HOLD_TICKS         (10),
      .STROBE_SYNC_STAGES (0)
   ) u0 (
      .clk          (clk),
      .rst          (rst),
      .cycle_mode_i (mode),
      .strobe_i     (strobe),
      .sleep_len_i  (sleep_len),
      .run_len_i    (run_len),
      .id_valid_i   (id_valid),
      .eom_i        (eom),
      .run_en_o     (run_en),
      .settled_o    (settled)
   );

   task automatic adv(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   // back to the always-awake state, settled
   task automatic go_idle();
      mode = 2'b00; strobe = 1'b0; id_valid = 1'b0; eom = 1'b0;
      adv(30);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      adv(3);
      rst = 1'b0;
      chk("R1", "run after reset", run_en, 1'b1);
      chk("R1", "settled after reset", settled, 1'b0);
      adv(15);
      chk("R1", "still settling", settled, 1'b0);
      adv(10);
      chk("R1", "settled later", settled, 1'b1);
      adv(100);
      chk("R2", "mode 00 stays awake", run_en, 1'b1);
   endtask

   task automatic t_external();
      go_idle();
      mode = 2'b01;
      adv(2);
      chk("R3", "ext strobe low", run_en, 1'b0);
      chk("R6", "asleep unsettled", settled, 1'b0);
      #1 strobe = 1'b1;
      #0.5;
      chk("R3", "ext strobe high same cycle", run_en, 1'b1);
      adv(10);
      chk("R6", "ext settling", settled, 1'b0);
      adv(15);
      chk("R6", "ext settled", settled, 1'b1);
      #1 strobe = 1'b0;
      #0.5;
      chk("R3", "ext strobe drop same cycle", run_en, 1'b0);
      adv(2);
      chk("R6", "settled clears on sleep", settled, 1'b0);
   endtask

   task automatic t_cycling(input logic [1:0] m);
      go_idle();
      mode = m;
      adv(20);
      chk("R5", "first run window", run_en, 1'b1);
      adv(25);
      chk("R5", "first sleep", run_en, 1'b0);
      adv(25);
      chk("R5", "second run window", run_en, 1'b1);
      chk("R6", "unsettled in new window", settled, 1'b0);
      adv(15);
      chk("R6", "settled in window", settled, 1'b1);
      adv(15);
      chk("R11", "second sleep", run_en, 1'b0);
      adv(25);
      chk("R11", "third run window", run_en, 1'b1);
   endtask

   task automatic t_early_id();
      go_idle();
      mode = 2'b10;
      adv(62);
      chk("R7", "before id, unsettled", settled, 1'b0);
      id_valid = 1'b1;
      adv(1);
      id_valid = 1'b0;
      adv(37);
      chk("R7", "early id ignored, asleep", run_en, 1'b0);
   endtask

   task automatic t_strobe_sleep();
      go_idle();
      mode = 2'b10;
      adv(45);
      chk("R5", "asleep before strobe", run_en, 1'b0);
      #1 strobe = 1'b1;
      #0.5;
      chk("R4", "strobe wakes same cycle", run_en, 1'b1);
      adv(1);
      strobe = 1'b0;
      adv(9);
      chk("R4", "strobe restarted window", run_en, 1'b1);
      adv(30);
      chk("R4", "restarted window ended", run_en, 1'b0);
   endtask

   task automatic t_hold_eom();
      go_idle();
      mode = 2'b10;
      adv(5);
      id_valid = 1'b1;
      adv(1);
      id_valid = 1'b0;
      adv(34);
      chk("R8", "id holds past window", run_en, 1'b1);
      eom = 1'b1;
      adv(1);
      eom = 1'b0;
      adv(2);
      chk("R9", "eom ends hold", run_en, 1'b0);
   endtask

   task automatic t_hold_timeout();
      go_idle();
      mode = 2'b10;
      adv(5);
      id_valid = 1'b1;
      adv(1);
      id_valid = 1'b0;
      adv(38);
      chk("R10", "hold before timeout", run_en, 1'b1);
      adv(6);
      chk("R10", "hold timed out", run_en, 1'b0);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_external();
      t_cycling(2'b10);
      t_cycling(2'b11);
      t_early_id();
      t_strobe_sleep();
      t_hold_eom();
      t_hold_timeout();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule